// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one cache coherent with its peers on an atomic shared bus. It holds a small direct-mapped store of one-word lines. Each line has a tag, a data word and one of four coherence states: Invalid, Shared, Exclusive (clean) or Modified. Processor reads and writes arrive over a valid/ready handshake. On a miss or an ownership upgrade, the controller puts a read, read-for-ownership or writeback request on the bus. It then waits for the completing cycle, in which the bus returns data and the wired-OR shared line.

In every cycle the controller also watches the transactions of the other caches. When a snoop hits a valid copy, the block answers in the same cycle. It asserts its shared output for a snooped read and puts Modified data on the bus with a flush strobe. At the clock edge it downgrades or invalidates the line. A dirty victim is moved to a one-entry writeback buffer before its line is refilled. Snoops also look in that buffer. If a snoop hits the buffer, the buffer supplies the data and the pending writeback is cancelled, because memory takes the flushed word.

The address is split into an index in its low `IDX_W` bits and a tag in the remaining upper bits. Bus and snoop commands use the encoding 0 = read, 1 = read-for-ownership, 2 = writeback. The bus is atomic, so a completing cycle (`busDone`) never coincides with a snoop.

Top module: `mesiSnoopCtrl`

## Requirements
- R1: After reset every line is Invalid. With no request pending, `cpuReady`, `busValid`, `snpShared` and `snpFlush` are low, and a snoop to any address gets no shared or flush response.
- R2: A read miss issues command 0 at the request address. In the cycle with `busDone` high, `cpuReady` rises and `cpuRdata` equals `busRdata`. The line becomes Exclusive if `busSharedIn` was low in that cycle, and Shared if it was high.
- R3: A read hit raises `cpuReady` in the same cycle as `cpuValid`, returns the stored word and starts no bus request.
- R4: A write to an Invalid or Shared line issues command 1 and leaves the line Modified with the written word. A write to an Exclusive or Modified line completes in the same cycle with no bus request.
- R5: A snooped read (0) that hits a valid copy asserts `snpShared` in that cycle. A Modified copy also raises `snpFlush` with its word on `snpFlushData`. Both Modified and Exclusive copies become Shared.
- R6: A snooped read-for-ownership (1) that hits a Modified copy flushes the word. Any valid copy it hits becomes Invalid, and it never asserts `snpShared`.
- R7: A miss whose victim is Modified first issues command 2 with the victim's address and word on `busWdata`, and then issues the fill. A clean victim is dropped with no writeback.
- R8: A snoop (0 or 1) that matches the address in the writeback buffer raises `snpFlush` with the buffered word and no `snpShared`. The pending writeback is then withdrawn, and the request goes on to its fill.
- R9: If a snoop hits the same index as a processor request in the same cycle, the snoop wins and `cpuReady` stays low. In the next cycle the request is evaluated against the updated state.
- R10: Once raised, a bus request keeps its command and address until `busDone`. The only exception is the withdrawal in R8.
- R11: A snooped writeback (2) gets no response and does not change any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request valid, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Request word address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` on a read |
| busValid | output | 1 | Own bus request pending |
| busCmd | output | 2 | Own request command (0 read, 1 read-for-ownership, 2 writeback) |
| busAddr | output | ADDR_W | Own request address |
| busWdata | output | DATA_W | Writeback word, zero for other commands |
| busDone | input | 1 | Own request completes this cycle |
| busRdata | input | DATA_W | Fill data in the completing cycle |
| busSharedIn | input | 1 | Wired-OR shared line sampled in the completing cycle |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped command |
| snpAddr | input | ADDR_W | Snooped address |
| snpShared | output | 1 | This cache holds a copy of the snooped read's line |
| snpFlush | output | 1 | This cache drives dirty data for the snoop |
| snpFlushData | output | DATA_W | Flushed word |

## Verification
The hardest case to reach from the ports is a snoop that arrives while a dirty victim sits in the writeback buffer. At that point the line itself is already Invalid, so only the buffer can answer. The bench holds the bus completion back for the first cycle in which the writeback request appears, and injects a snooped read to exactly that victim address in that same cycle. It then expects a flush from the buffer, the request to drop, and a fill to follow, and a later read confirms that memory took the flushed word. The snoop-versus-processor race is produced by raising both on the same index in one cycle.

// File: rtl/mesiPkg.sv
package mesiPkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2,
    LINE_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_WB  = 2'd2,
    CMD_NOP = 2'd3
  } busCmd_t;

  typedef struct packed {
    logic       lineWr;       // write tag, data and state of the request line
    lineState_t newState;
    logic       takeBusData;  // fill word comes from the bus, else from the processor
    logic       evict;        // move the dirty victim into the writeback buffer
    logic       wbClear;      // writeback accepted by the bus
    logic       rdFromBus;    // read data returns straight from the bus
    logic       useWb;        // bus address and data come from the buffer
  } ctrlStrobe_t;

endpackage

// File: rtl/mesiDatapath.sv
module mesiDatapath
  import mesiPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  busCmd_t           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  ctrlStrobe_t       strobe,
  output logic              cpuHit,
  output lineState_t        cpuLineState,
  output logic              victimDirty,
  output logic              snpSameIdx,
  output logic              wbValid,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpLineHit, snpWbHit, snpActive;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // processor-side lookup
  assign cpuLineState = stArr[cpuIdx];
  assign cpuHit       = (stArr[cpuIdx] != LINE_I) && (tagArr[cpuIdx] == cpuTag);
  assign victimDirty  = !cpuHit && (stArr[cpuIdx] == LINE_M);
  assign cpuRdata     = strobe.rdFromBus ? busRdata : dataArr[cpuIdx];

  // bus-side lookup: line store and writeback buffer
  assign snpActive  = snpValid && ((snpCmd == CMD_RD) || (snpCmd == CMD_RDX));
  assign snpSameIdx = snpValid && (snpIdx == cpuIdx);
  assign snpLineHit = snpActive && (stArr[snpIdx] != LINE_I) && (tagArr[snpIdx] == snpTag);
  assign snpWbHit   = snpActive && wbValid && (wbAddr == snpAddr);

  assign snpShared    = snpLineHit && (snpCmd == CMD_RD);
  assign snpFlush     = snpWbHit || (snpLineHit && (stArr[snpIdx] == LINE_M));
  assign snpFlushData = snpWbHit ? wbData : dataArr[snpIdx];

  assign busAddr  = strobe.useWb ? wbAddr : cpuAddr;
  assign busWdata = strobe.useWb ? wbData : '0;

  // state array: snoop update has priority over the processor side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LINE_I;
    end else begin
      if (snpLineHit)
        stArr[snpIdx] <= (snpCmd == CMD_RDX) ? LINE_I : LINE_S;
      if (!(snpLineHit && (snpIdx == cpuIdx))) begin
        if (strobe.lineWr)
          stArr[cpuIdx] <= strobe.newState;
        else if (strobe.evict)
          stArr[cpuIdx] <= LINE_I;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.lineWr) begin
      tagArr[cpuIdx]  <= cpuTag;
      dataArr[cpuIdx] <= strobe.takeBusData ? busRdata : cpuWdata;
    end
  end

  // one-entry writeback buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else if (strobe.evict) begin
      wbValid <= 1'b1;
      wbAddr  <= {tagArr[cpuIdx], cpuIdx};
      wbData  <= dataArr[cpuIdx];
    end else if (strobe.wbClear || snpWbHit) begin
      wbValid <= 1'b0;
    end
  end

endmodule

// File: rtl/mesiCtrl.sv
module mesiCtrl
  import mesiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  logic        cpuHit,
  input  lineState_t  cpuLineState,
  input  logic        victimDirty,
  input  logic        snpSameIdx,
  input  logic        wbValid,
  input  logic        busDone,
  input  logic        busSharedIn,
  output logic        cpuReady,
  output logic        busValid,
  output busCmd_t     busCmd,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } ctrlState_t;

  ctrlState_t curSt, nxtSt;
  busCmd_t    fillCmd, nxtFillCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSt   <= ST_IDLE;
      fillCmd <= CMD_RD;
    end else begin
      curSt   <= nxtSt;
      fillCmd <= nxtFillCmd;
    end
  end

  always_comb begin
    nxtSt      = curSt;
    nxtFillCmd = fillCmd;
    cpuReady   = 1'b0;
    busValid   = 1'b0;
    busCmd     = CMD_NOP;
    strobe     = '0;
    unique case (curSt)
      ST_IDLE: begin
        if (cpuValid && !snpSameIdx) begin
          if (cpuHit) begin
            if (!cpuWrite) begin
              cpuReady = 1'b1;
            end else if (cpuLineState == LINE_S) begin
              nxtSt      = ST_FILL;
              nxtFillCmd = CMD_RDX;
            end else begin
              cpuReady        = 1'b1;
              strobe.lineWr   = 1'b1;
              strobe.newState = LINE_M;
            end
          end else if (victimDirty) begin
            strobe.evict = 1'b1;
            nxtSt        = ST_WB;
          end else begin
            nxtSt      = ST_FILL;
            nxtFillCmd = cpuWrite ? CMD_RDX : CMD_RD;
          end
        end
      end
      ST_WB: begin
        strobe.useWb = 1'b1;
        if (!wbValid) begin
          nxtSt = ST_IDLE;
        end else begin
          busValid = 1'b1;
          busCmd   = CMD_WB;
          if (busDone) begin
            strobe.wbClear = 1'b1;
            nxtSt          = ST_IDLE;
          end
        end
      end
      ST_FILL: begin
        busValid = 1'b1;
        busCmd   = fillCmd;
        if (busDone) begin
          cpuReady           = 1'b1;
          strobe.lineWr      = 1'b1;
          strobe.rdFromBus   = 1'b1;
          strobe.takeBusData = (fillCmd == CMD_RD);
          strobe.newState    = (fillCmd == CMD_RDX) ? LINE_M :
                               (busSharedIn ? LINE_S : LINE_E);
          nxtSt              = ST_IDLE;
        end
      end
      default: nxtSt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mesiSnoopCtrl.sv
module mesiSnoopCtrl
  import mesiPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  ctrlStrobe_t strobe;
  lineState_t  lineState;
  busCmd_t     ctrlCmd;
  logic        cpuHit, victimDirty, snpSameIdx, wbValid;

  mesiCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .cpuWrite    (cpuWrite),
    .cpuHit      (cpuHit),
    .cpuLineState(lineState),
    .victimDirty (victimDirty),
    .snpSameIdx  (snpSameIdx),
    .wbValid     (wbValid),
    .busDone     (busDone),
    .busSharedIn (busSharedIn),
    .cpuReady    (cpuReady),
    .busValid    (busValid),
    .busCmd      (ctrlCmd),
    .strobe      (strobe)
  );

  mesiDatapath #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .busRdata    (busRdata),
    .snpValid    (snpValid),
    .snpCmd      (busCmd_t'(snpCmd)),
    .snpAddr     (snpAddr),
    .strobe      (strobe),
    .cpuHit      (cpuHit),
    .cpuLineState(lineState),
    .victimDirty (victimDirty),
    .snpSameIdx  (snpSameIdx),
    .wbValid     (wbValid),
    .cpuRdata    (cpuRdata),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .snpShared   (snpShared),
    .snpFlush    (snpFlush),
    .snpFlushData(snpFlushData)
  );

  assign busCmd = ctrlCmd;

endmodule

// File: rtl/mesiSnoopChk.sv
module mesiSnoopChk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuReady,
  input logic              busValid,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDone,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpShared,
  input logic              snpFlush
);

  // R5 R6
  shared_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpShared |-> (snpValid && snpCmd == 2'd0));

  // R5 R6 R8
  flush_only_on_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> (snpValid && (snpCmd == 2'd0 || snpCmd == 2'd1)));

  // R11
  wb_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd2) |-> (!snpShared && !snpFlush));

  // R5 R6: after a flush the copy is no longer Modified
  single_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |=> !(snpFlush && snpAddr == $past(snpAddr)));

  // R10
  bus_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busDone && !snpValid) |=>
      (busValid && $stable(busCmd) && $stable(busAddr)));

  // R3 R4
  ready_no_open_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (!busValid || busDone));

  // R9
  snoop_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && snpValid && !busValid &&
     snpAddr[IDX_W-1:0] == cpuAddr[IDX_W-1:0]) |-> !cpuReady);

endmodule

bind mesiSnoopCtrl mesiSnoopChk #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_mesiChk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuValid (cpuValid),
  .cpuAddr  (cpuAddr),
  .cpuReady (cpuReady),
  .busValid (busValid),
  .busCmd   (busCmd),
  .busAddr  (busAddr),
  .busDone  (busDone),
  .snpValid (snpValid),
  .snpCmd   (snpCmd),
  .snpAddr  (snpAddr),
  .snpShared(snpShared),
  .snpFlush (snpFlush)
);

// File: tb/test_mesiSnoopCtrl.sv
module test_mesiSnoopCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_M = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic              cpuReady;
  logic [DATA_W-1:0] cpuRdata;
  logic              busValid;
  logic [1:0]        busCmd;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic              busDone = 1'b0;
  logic [DATA_W-1:0] busRdata = '0;
  logic              busSharedIn = 1'b0;
  logic              snpValid = 1'b0;
  logic [1:0]        snpCmd = '0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic              snpShared, snpFlush;
  logic [DATA_W-1:0] snpFlushData;

  int checks = 0;
  int failures = 0;

  // reference model
  int                mSt   [LINES];
  logic [ADDR_W-1:0] mLineA[LINES];
  logic [DATA_W-1:0] mData [LINES];
  logic [DATA_W-1:0] mem   [int];
  logic [1:0]        qCmd  [$];
  logic [ADDR_W-1:0] qAddr [$];
  logic [DATA_W-1:0] qData [$];

  mesiSnoopCtrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_mesiSnoopCtrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busValid(busValid), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busDone(busDone), .busRdata(busRdata), .busSharedIn(busSharedIn),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush), .snpFlushData(snpFlushData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] memVal(input logic [ADDR_W-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h5A00_0000 | DATA_W'(a);
  endfunction

  function automatic bit mHit(input logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    return (mSt[idx] != ST_I) && (mLineA[idx] == a);
  endfunction

  // model response of this cache to a foreign transaction
  task automatic snoopModel(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                            output bit sh, output bit fl, output logic [DATA_W-1:0] fd);
    int idx = int'(a[IDX_W-1:0]);
    bit hit = mHit(a) && (cmd != 2'd2);
    sh = hit && (cmd == 2'd0);
    fl = hit && (mSt[idx] == ST_M);
    fd = mData[idx];
    if (fl) mem[int'(a)] = fd;
    if (hit) mSt[idx] = (cmd == 2'd1) ? ST_I : ST_S;
  endtask

  task automatic doSnoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a, input string req);
    bit sh, fl;
    logic [DATA_W-1:0] fd;
    snoopModel(cmd, a, sh, fl, fd);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a;
    #1;
    chk(snpShared == sh, req, "snoop shared", 32'(snpShared), 32'(sh));
    chk(snpFlush == fl, req, "snoop flush", 32'(snpFlush), 32'(fl));
    if (fl) chk(snpFlushData == fd, req, "snoop flush data", snpFlushData, fd);
    @(posedge clk);
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic doCpu(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input bit shr, input bit snoopWb, input int raceCmd,
                       input logic [ADDR_W-1:0] raceAddr, input string req);
    int idx = int'(a[IDX_W-1:0]);
    bit rSh = 1'b0, rFl = 1'b0, hit, done = 1'b0;
    logic [DATA_W-1:0] rFd = '0, expR;
    int cyc = 0, waitCnt = 0;
    bit quiet;
    if (raceCmd >= 0) snoopModel(2'(raceCmd), raceAddr, rSh, rFl, rFd);
    hit = mHit(a);
    qCmd.delete(); qAddr.delete(); qData.delete();
    if (hit && w && mSt[idx] == ST_S) begin
      qCmd.push_back(2'd1); qAddr.push_back(a); qData.push_back('0);
    end else if (!hit) begin
      if (mSt[idx] == ST_M) begin
        qCmd.push_back(2'd2); qAddr.push_back(mLineA[idx]); qData.push_back(mData[idx]);
      end
      qCmd.push_back(w ? 2'd1 : 2'd0); qAddr.push_back(a); qData.push_back('0);
    end
    quiet = (qCmd.size() == 0);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a; cpuWdata = wd;
    if (raceCmd >= 0) begin
      snpValid = 1'b1; snpCmd = 2'(raceCmd); snpAddr = raceAddr;
    end
    while (!done && cyc < 40) begin
      #1;
      if (cyc == 0 && raceCmd >= 0) begin
        chk(cpuReady == 1'b0, "R9", "stall on snoop to same index", 32'(cpuReady), 0);
        chk(snpFlush == rFl && snpShared == rSh, "R9", "race snoop response",
            {snpFlush, snpShared}, {rFl, rSh});
      end
      if (busValid) begin
        if (qCmd.size() == 0) begin
          chk(1'b0, req, "unexpected bus request", 32'(busCmd), 32'hFFFF);
        end else begin
          chk(busCmd == qCmd[0], "R10", "bus command", 32'(busCmd), 32'(qCmd[0]));
          chk(busAddr == qAddr[0], "R10", "bus address", 32'(busAddr), 32'(qAddr[0]));
          if (qCmd[0] == 2'd2)
            chk(busWdata == qData[0], "R7", "writeback data", busWdata, qData[0]);
          if (snoopWb && qCmd[0] == 2'd2 && waitCnt == 0) begin
            snpValid = 1'b1; snpCmd = 2'd0; snpAddr = qAddr[0];
            #1;
            chk(snpFlush == 1'b1, "R8", "flush from writeback buffer", 32'(snpFlush), 1);
            chk(snpFlushData == qData[0], "R8", "buffer flush data", snpFlushData, qData[0]);
            chk(snpShared == 1'b0, "R8", "no shared from buffer", 32'(snpShared), 0);
            mem[int'(qAddr[0])] = qData[0];
            void'(qCmd.pop_front()); void'(qAddr.pop_front()); void'(qData.pop_front());
          end else begin
            waitCnt++;
            if (waitCnt == 2) begin
              busDone = 1'b1;
              busRdata = memVal(busAddr);
              busSharedIn = shr;
              if (qCmd[0] == 2'd2) mem[int'(qAddr[0])] = qData[0];
              void'(qCmd.pop_front()); void'(qAddr.pop_front()); void'(qData.pop_front());
              waitCnt = 0;
              #1;
            end
          end
        end
      end
      if (cpuReady) begin
        done = 1'b1;
        chk(qCmd.size() == 0, req, "pending bus transactions at completion",
            32'(qCmd.size()), 0);
        if (quiet)
          chk(cyc == ((raceCmd >= 0) ? 1 : 0), req, "completion cycle", 32'(cyc),
              (raceCmd >= 0) ? 1 : 0);
        if (!w) begin
          expR = hit ? mData[idx] : memVal(a);
          chk(cpuRdata == expR, req, "read data", cpuRdata, expR);
        end
      end
      @(posedge clk);
      @(negedge clk);
      busDone = 1'b0;
      snpValid = 1'b0;
      cyc++;
    end
    cpuValid = 1'b0;
    if (!done) chk(1'b0, req, "request never completed", 0, 1);
    if (w) begin
      mSt[idx] = ST_M; mData[idx] = wd;
    end else if (!hit) begin
      mSt[idx] = shr ? ST_S : ST_E; mData[idx] = memVal(a);
    end
    mLineA[idx] = a;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      mSt[i] = ST_I; mLineA[i] = '0; mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(cpuReady == 0 && busValid == 0, "R1", "idle outputs in reset", {cpuReady, busValid}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(snpShared == 0 && snpFlush == 0, "R1", "snoop outputs idle", {snpShared, snpFlush}, 0);
    doSnoop(2'd0, 8'h04, "R1");
    doSnoop(2'd1, 8'h00, "R1");

    doCpu(1'b0, 8'h04, '0, 1'b0, 1'b0, -1, '0, "R2");   // miss -> E
    doCpu(1'b0, 8'h04, '0, 1'b0, 1'b0, -1, '0, "R3");   // hit
    doCpu(1'b1, 8'h04, 32'hAAAA_0001, 1'b0, 1'b0, -1, '0, "R4");  // E -> M, no bus
    doSnoop(2'd0, 8'h04, "R5");                          // M flush -> S
    doCpu(1'b1, 8'h04, 32'hBBBB_0002, 1'b0, 1'b0, -1, '0, "R4");  // S -> RdX -> M
    doSnoop(2'd1, 8'h04, "R6");                          // M flush -> I
    doCpu(1'b0, 8'h04, '0, 1'b1, 1'b0, -1, '0, "R6");   // miss after invalidate, -> S
    doSnoop(2'd0, 8'h04, "R5");                          // shared, no flush
    doSnoop(2'd1, 8'h04, "R6");                          // S -> I, silent
    doCpu(1'b0, 8'h05, '0, 1'b0, 1'b0, -1, '0, "R2");   // -> E
    doSnoop(2'd0, 8'h05, "R5");                          // E -> S
    doCpu(1'b1, 8'h05, 32'hCCCC_0003, 1'b0, 1'b0, -1, '0, "R4");  // S proves downgrade

    doCpu(1'b0, 8'h09, '0, 1'b0, 1'b0, -1, '0, "R7");   // dirty victim writeback
    doCpu(1'b0, 8'h0D, '0, 1'b0, 1'b0, -1, '0, "R7");   // clean victim silent
    doCpu(1'b0, 8'h05, '0, 1'b0, 1'b0, -1, '0, "R7");   // memory holds written-back word

    doCpu(1'b1, 8'h02, 32'hDDDD_0004, 1'b0, 1'b0, -1, '0, "R4");
    doCpu(1'b1, 8'h06, 32'hEEEE_0005, 1'b0, 1'b1, -1, '0, "R8");  // snoop hits buffer
    doCpu(1'b0, 8'h02, '0, 1'b0, 1'b0, -1, '0, "R8");   // flushed word reached memory

    doCpu(1'b0, 8'h03, '0, 1'b0, 1'b0, -1, '0, "R2");
    doCpu(1'b0, 8'h03, '0, 1'b0, 1'b0, 1, 8'h03, "R9");  // RdX race invalidates, re-miss
    doCpu(1'b0, 8'h07, '0, 1'b1, 1'b0, 0, 8'h03, "R9");  // race on same index, miss anyway

    doCpu(1'b1, 8'h0B, 32'h1234_0006, 1'b0, 1'b0, -1, '0, "R4");
    doSnoop(2'd2, 8'h0B, "R11");
    doCpu(1'b1, 8'h0B, 32'h5678_0007, 1'b0, 1'b0, -1, '0, "R11");  // still M: no bus
    doCpu(1'b0, 8'h0B, '0, 1'b0, 1'b0, -1, '0, "R11");
    doSnoop(2'd0, 8'h1B, "R5");                          // other tag, same index

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule